// File: doc/BRIEF.md
# Clock, Reset and Power-Mode Controller

This block sits between the clock input of an 8-bit microcontroller and the rest of the chip. It forms an internal clock from the input clock. With an external clock source, the input clock is halved by a divide-by-two stage. A modulo-12 counter then produces a one-clock machine-cycle strobe, so one machine cycle lasts 12 internal clocks. The block does not generate new clocks. Every internal clock is a qualifying enable pulse on the input clock domain. The core and the peripherals use the gated enables that the block outputs.

The active-high reset pin is asynchronous to the clock. It passes through a two-flop synchronizer and then a qualification counter, which filters out short glitches. While a qualified reset is present, the block drives the synchronous core reset. During that time it also drives load strobes that put the reset defaults into the special function registers. The stack-pointer slot gets 07h, every other slot gets 00h, and the serial data buffer slot receives no load strobe, so its contents survive. A separate strobe per port sets the output latches high.

A two-bit power-control register holds an idle bit and a power-down bit. Idle stops only the core enable, and an interrupt wake request or a reset ends it. Power-down stops every enable, and only a reset ends it.

Top module: `clk_rst_pwr_ctl`

## Requirements
- R1: With `ext_clk_sel`=0, the internal clock runs at the input rate, and `mc_strobe` is one input clock wide and recurs every 12 input clocks.
- R2: With `ext_clk_sel`=1, the internal clock is the input clock divided by two. `mc_strobe` recurs every 24 input clocks, and `core_clk_en` and `periph_clk_en` are high on alternate input clocks.
- R3: A reset-pin pulse is qualified only after the synchronized pin has been high for 24 consecutive internal clocks. With `ext_clk_sel`=0, a pulse held for N input clocks gives N-23 cycles of `core_rst` when N≥24, and none when N<24. `core_rst` first shows 26 clocks after the pin rises.
- R4: Any low cycle of the synchronized pin restarts qualification from zero. Two 20-clock high pulses separated by one low clock give no `core_rst`.
- R5: While `core_rst` is high, `sfr_rst_ld` has every bit set except index `BUF_IDX` (3), which stays 0. `sfr_rst_val` holds 07h in byte slot `SP_IDX` (1) and 00h in every other slot, where slot i is bits [8i+7:8i].
- R6: While `core_rst` is high, every bit of `port_set` is 1.
- R7: With the idle bit set and power-down clear, `core_clk_en` is 0, while `periph_clk_en`, `mc_strobe` and `osc_en` keep running.
- R8: A `wake_req` while idle is set and power-down is clear clears the idle bit at the next clock, and `core_clk_en` resumes.
- R9: With the power-down bit set, `osc_en`, `core_clk_en`, `periph_clk_en` and `mc_strobe` are all 0. `wake_req` leaves both bits unchanged, and a qualified reset clears power-down.
- R10: With both bits set, power-down behaviour applies, and `wake_req` clears neither bit.
- R11: A qualified reset, or the power-on `rst`, clears both power-control bits. A register write in a cycle where `core_rst` is high is overridden.
- R12: The write encoding is `pcon_wdata[0]`=idle and `pcon_wdata[1]`=power-down. A write that sets idle in the same cycle as a `wake_req` (with idle previously clear) leaves idle set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk | input | 1 | Input clock from the oscillator or external source |
| rst | input | 1 | Synchronous active-high power-on reset |
| ext_clk_sel | input | 1 | 1 = external clock source, halve the input rate |
| rst_pin | input | 1 | Asynchronous active-high external reset pin |
| wake_req | input | 1 | Enabled interrupt request from the interrupt logic |
| pcon_we | input | 1 | Write strobe for the power-control register |
| pcon_wdata | input | 2 | Write data: bit 0 idle, bit 1 power-down |
| core_rst | output | 1 | Synchronous core reset |
| mc_strobe | output | 1 | One-clock strobe at the start of each machine cycle |
| core_clk_en | output | 1 | Gated clock enable for the core |
| periph_clk_en | output | 1 | Gated clock enable for peripherals |
| osc_en | output | 1 | Oscillator enable, low in power-down |
| idle_st | output | 1 | Idle bit of the power-control register |
| pd_st | output | 1 | Power-down bit of the power-control register |
| sfr_rst_ld | output | NUM_SFR | Per-register reset-default load strobes |
| sfr_rst_val | output | NUM_SFR*8 | Reset default value for each register slot |
| port_set | output | NUM_PORTS | Per-port strobe that sets the output latches high |

## Verification
Two updates to the power-control register can fall in the same cycle:
- A software write can coincide with a wake request. The bench drives a write of the idle bit and `wake_req` on the same clock while idle is clear, and expects idle set afterwards.
- A software write can land in a cycle where the qualified reset is active. The bench holds the pin long enough that `core_rst` is seen, writes both bits in that exact cycle, and expects both bits clear afterwards.

The qualification length is swept over every pulse width from 1 to 30 clocks. Each observed count of `core_rst` cycles is compared with N-23.

// File: rtl/clkpm_pkg.sv
package clkpm_pkg;

    localparam int MC_LEN_DFLT  = 12;
    localparam int QUAL_MC_DFLT = 2;

    typedef struct packed {
        logic pd;
        logic idle;
    } pwr_ctl_t;

    function automatic logic [7:0] sfr_default(input int idx, input int sp_idx,
                                               input logic [7:0] sp_val);
        return (idx == sp_idx) ? sp_val : 8'h00;
    endfunction

endpackage

// File: rtl/mc_timebase.sv
module mc_timebase #(
    parameter int MC_LEN = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_sel,
    input  logic freeze,
    output logic tick,
    output logic mc_strobe
);
    localparam int CW = (MC_LEN > 1) ? $clog2(MC_LEN) : 1;

    logic          half_q;
    logic [CW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst)          half_q <= 1'b0;
        else if (ext_sel) half_q <= ~half_q;
        else              half_q <= 1'b0;
    end

    assign tick = ~ext_sel | half_q;

    always_ff @(posedge clk) begin
        if (rst)
            phase_q <= '0;
        else if (tick && !freeze)
            phase_q <= (phase_q == CW'(MC_LEN - 1)) ? '0 : phase_q + 1'b1;
    end

    assign mc_strobe = tick & ~freeze & (phase_q == '0);

    // R1
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        mc_strobe |=> !mc_strobe);

endmodule

// File: rtl/rst_qualify.sv
module rst_qualify #(
    parameter int QUAL_TICKS = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic tick,
    output logic core_rst
);
    localparam int QW = $clog2(QUAL_TICKS + 1);

    logic [1:0]    sync_q;
    logic [QW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b00;
        else     sync_q <= {sync_q[0], pin};
    end

    always_ff @(posedge clk) begin
        if (rst || !sync_q[1])
            run_q <= '0;
        else if (tick && run_q != QW'(QUAL_TICKS))
            run_q <= run_q + 1'b1;
    end

    assign core_rst = (run_q == QW'(QUAL_TICKS));

    // R4
    low_restarts_chk: assert property (@(posedge clk) disable iff (rst)
        !sync_q[1] |=> !core_rst);

    // R3
    rise_needs_high_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(core_rst) |-> $past(sync_q[1]));

endmodule

// File: rtl/pwr_state.sv
module pwr_state
    import clkpm_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     core_rst,
    input  logic     tick,
    input  logic     wake_req,
    input  logic     wr_en,
    input  pwr_ctl_t wr_val,
    output pwr_ctl_t st,
    output logic     core_clk_en,
    output logic     periph_clk_en,
    output logic     osc_en
);
    always_ff @(posedge clk) begin
        if (rst || core_rst)
            st <= '0;
        else if (wake_req && st.idle && !st.pd)
            st.idle <= 1'b0;
        else if (wr_en)
            st <= wr_val;
    end

    assign osc_en        = ~st.pd;
    assign periph_clk_en = tick & ~st.pd;
    assign core_clk_en   = tick & ~st.pd & ~st.idle;

    // R8
    wake_leaves_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (st.idle && !st.pd && wake_req && !core_rst) |=> !st.idle);

    // R9
    pd_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (st.pd && !core_rst && !wr_en) |=> (st.pd && $stable(st.idle)));

    // R11
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        core_rst |=> (!st.pd && !st.idle));

endmodule

// File: rtl/clk_rst_pwr_ctl.sv
module clk_rst_pwr_ctl
    import clkpm_pkg::*;
#(
    parameter int         MC_LEN    = MC_LEN_DFLT,
    parameter int         QUAL_MC   = QUAL_MC_DFLT,
    parameter int         NUM_SFR   = 8,
    parameter int         SP_IDX    = 1,
    parameter int         BUF_IDX   = 3,
    parameter logic [7:0] SP_RST    = 8'h07,
    parameter int         NUM_PORTS = 4
) (
    input  logic                 osc_clk,
    input  logic                 rst,
    input  logic                 ext_clk_sel,
    input  logic                 rst_pin,
    input  logic                 wake_req,
    input  logic                 pcon_we,
    input  logic [1:0]           pcon_wdata,
    output logic                 core_rst,
    output logic                 mc_strobe,
    output logic                 core_clk_en,
    output logic                 periph_clk_en,
    output logic                 osc_en,
    output logic                 idle_st,
    output logic                 pd_st,
    output logic [NUM_SFR-1:0]   sfr_rst_ld,
    output logic [NUM_SFR*8-1:0] sfr_rst_val,
    output logic [NUM_PORTS-1:0] port_set
);
    localparam int QUAL_TICKS = QUAL_MC * MC_LEN;

    logic     tick;
    pwr_ctl_t st;
    pwr_ctl_t wr_val;

    assign wr_val = pwr_ctl_t'(pcon_wdata);

    mc_timebase #(.MC_LEN(MC_LEN)) u_tb (
        .clk(osc_clk), .rst(rst), .ext_sel(ext_clk_sel), .freeze(st.pd),
        .tick(tick), .mc_strobe(mc_strobe)
    );

    rst_qualify #(.QUAL_TICKS(QUAL_TICKS)) u_rq (
        .clk(osc_clk), .rst(rst), .pin(rst_pin), .tick(tick), .core_rst(core_rst)
    );

    pwr_state u_ps (
        .clk(osc_clk), .rst(rst), .core_rst(core_rst), .tick(tick),
        .wake_req(wake_req), .wr_en(pcon_we), .wr_val(wr_val), .st(st),
        .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en), .osc_en(osc_en)
    );

    assign idle_st = st.idle;
    assign pd_st   = st.pd;

    for (genvar i = 0; i < NUM_SFR; i++) begin : g_sfr
        localparam logic KEEP = (i == BUF_IDX);
        assign sfr_rst_ld[i]        = core_rst & ~KEEP;
        assign sfr_rst_val[i*8 +: 8] = sfr_default(i, SP_IDX, SP_RST);
    end

    assign port_set = {NUM_PORTS{core_rst}};

    // R9
    pd_quiet_chk: assert property (@(posedge osc_clk) disable iff (rst)
        pd_st |-> (!mc_strobe && !core_clk_en && !periph_clk_en));

endmodule

// File: tb/sim_clk_rst_pwr_ctl.sv
module sim_clk_rst_pwr_ctl;
    logic osc_clk = 1'b0;
    logic rst = 1'b1;
    logic ext_clk_sel = 1'b0;
    logic rst_pin = 1'b0;
    logic wake_req = 1'b0;
    logic pcon_we = 1'b0;
    logic [1:0] pcon_wdata = 2'b00;
    logic core_rst, mc_strobe, core_clk_en, periph_clk_en, osc_en, idle_st, pd_st;
    logic [7:0]  sfr_rst_ld;
    logic [63:0] sfr_rst_val;
    logic [3:0]  port_set;

    int nvec = 0;
    int nerr = 0;
    int wd   = 0;

    always #5 osc_clk = ~osc_clk;

    clk_rst_pwr_ctl u0 (
        .osc_clk(osc_clk), .rst(rst), .ext_clk_sel(ext_clk_sel), .rst_pin(rst_pin),
        .wake_req(wake_req), .pcon_we(pcon_we), .pcon_wdata(pcon_wdata),
        .core_rst(core_rst), .mc_strobe(mc_strobe), .core_clk_en(core_clk_en),
        .periph_clk_en(periph_clk_en), .osc_en(osc_en), .idle_st(idle_st),
        .pd_st(pd_st), .sfr_rst_ld(sfr_rst_ld), .sfr_rst_val(sfr_rst_val),
        .port_set(port_set)
    );

    always @(posedge osc_clk) begin
        wd++;
        if (wd > 100000) begin
            nerr++;
            $display("FAIL watchdog R1 actual=%0d expected<=100000 cycles", wd);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nvec++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge osc_clk);
    endtask

    task automatic measure(input int ncyc, input int period, input string tag,
                           output int nstb, output int ncore, output int nper);
        int last = -1;
        nstb = 0; ncore = 0; nper = 0;
        for (int k = 0; k < ncyc; k++) begin
            cyc();
            if (core_clk_en) ncore++;
            if (periph_clk_en) nper++;
            if (mc_strobe) begin
                if (last >= 0) chk($sformatf("%s strobe period", tag), k - last, period);
                last = k;
                nstb++;
            end
        end
    endtask

    task automatic pulse_rst(input int len, input int tail, output int hi, output int first);
        logic [63:0] expv;
        hi = 0; first = -1;
        rst_pin = 1'b1;
        for (int k = 1; k <= len + tail; k++) begin
            cyc();
            if (core_rst) begin
                if (first < 0) begin
                    first = k;
                    chk("R5 load strobes", {56'd0, sfr_rst_ld}, 64'h00F7);
                    expv = '0;
                    for (int i = 0; i < 8; i++) expv[i*8 +: 8] = (i == 1) ? 8'h07 : 8'h00;
                    chk("R5 default values", sfr_rst_val, expv);
                    chk("R6 port set", {60'd0, port_set}, 64'hF);
                end
                hi++;
            end
            if (k == len) rst_pin = 1'b0;
        end
    endtask

    task automatic write_pcon(input logic [1:0] v);
        pcon_wdata = v; pcon_we = 1'b1;
        cyc();
        pcon_we = 1'b0;
    endtask

    initial begin
        int ns, nc, np, hi, first;
        repeat (4) cyc();
        chk("R11 reset idle", idle_st, 1'b0);
        chk("R11 reset pd", pd_st, 1'b0);
        chk("R3 reset core_rst", core_rst, 1'b0);
        chk("R9 reset osc_en", osc_en, 1'b1);
        rst = 1'b0;

        measure(60, 12, "R1", ns, nc, np);
        chk("R1 strobe count", ns, 5);
        chk("R1 core enable count", nc, 60);

        ext_clk_sel = 1'b1;
        repeat (30) cyc();
        measure(96, 24, "R2", ns, nc, np);
        chk("R2 strobe count", ns, 4);
        chk("R2 core enable count", nc, 48);
        chk("R2 periph enable count", np, 48);
        pulse_rst(40, 60, hi, first);
        chk("R3 ext short pulse", hi, 0);
        pulse_rst(60, 60, hi, first);
        chk("R3 ext long pulse seen", (hi > 0), 1'b1);
        ext_clk_sel = 1'b0;
        repeat (30) cyc();

        for (int n = 1; n <= 30; n++) begin
            pulse_rst(n, 30, hi, first);
            chk($sformatf("R3 len=%0d reset cycles", n), hi, (n >= 24) ? n - 23 : 0);
            if (n >= 24) chk($sformatf("R3 len=%0d latency", n), first, 26);
        end

        // R4: one-clock gap restarts qualification
        rst_pin = 1'b1;
        hi = 0;
        for (int k = 1; k <= 80; k++) begin
            cyc();
            if (core_rst) hi++;
            if (k == 20) rst_pin = 1'b0;
            if (k == 21) rst_pin = 1'b1;
            if (k == 41) rst_pin = 1'b0;
        end
        chk("R4 gapped pulses", hi, 0);

        write_pcon(2'b01);
        chk("R7 idle set", idle_st, 1'b1);
        measure(24, 12, "R7", ns, nc, np);
        chk("R7 core enable stopped", nc, 0);
        chk("R7 periph enable runs", np, 24);
        chk("R7 strobes run", ns, 2);
        chk("R7 osc_en", osc_en, 1'b1);

        wake_req = 1'b1; cyc(); wake_req = 1'b0;
        chk("R8 idle cleared", idle_st, 1'b0);
        chk("R8 core enable resumes", core_clk_en, 1'b1);

        write_pcon(2'b10);
        measure(30, 12, "R9", ns, nc, np);
        chk("R9 strobes", ns, 0);
        chk("R9 core enable", nc, 0);
        chk("R9 periph enable", np, 0);
        chk("R9 osc_en", osc_en, 1'b0);
        wake_req = 1'b1; cyc(); wake_req = 1'b0;
        cyc();
        chk("R9 wake ignored pd", pd_st, 1'b1);
        chk("R9 wake ignored idle", idle_st, 1'b0);
        pulse_rst(30, 10, hi, first);
        chk("R9 reset exits pd", pd_st, 1'b0);
        chk("R9 osc restored", osc_en, 1'b1);

        write_pcon(2'b11);
        chk("R10 osc_en", osc_en, 1'b0);
        chk("R10 core enable", core_clk_en, 1'b0);
        wake_req = 1'b1; cyc(); wake_req = 1'b0;
        cyc();
        chk("R10 idle kept", idle_st, 1'b1);
        chk("R10 pd kept", pd_st, 1'b1);

        // R11: write lands in a reset cycle
        rst_pin = 1'b1;
        for (int k = 0; k < 40 && !core_rst; k++) cyc();
        chk("R11 reset reached", core_rst, 1'b1);
        write_pcon(2'b11);
        chk("R11 write overridden idle", idle_st, 1'b0);
        chk("R11 write overridden pd", pd_st, 1'b0);
        rst_pin = 1'b0;
        repeat (30) cyc();

        // R12: write of idle with wake in the same cycle
        wake_req = 1'b1;
        write_pcon(2'b01);
        wake_req = 1'b0;
        chk("R12 idle set despite wake", idle_st, 1'b1);
        wake_req = 1'b1; cyc(); wake_req = 1'b0;
        chk("R8 second wake", idle_st, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule